// File: doc/BRIEF.md
# Serial EEPROM Boot Configuration Loader

This block brings a chip into its configured state straight out of reset. In the first cycle after reset it looks at a boot-select input. When that input is high, it becomes the master of a four-wire serial bus and issues one sequential read to an external serial EEPROM. It then parses the returned bytes as a stream of configuration records. When the input is low, the block stays idle and leaves the bus released.

A record is a one-byte command. A command may be followed by up to three 24-bit data words, each stored as three bytes. The command byte sets how many words follow. Each command and each assembled word is handed to the downstream configuration logic over a valid/ready interface. While the consumer is not ready, the serial clock stops low and chip select stays asserted, so the same sequential read carries on afterwards.

The stream ends when the start command is accepted. The block then raises `done_o` and releases the bus, which lets an external programmer take over the wires. An unknown command stops the load and raises `err_o`. So does running out of address space before the stream is finished.

Top module: `spi_boot_loader`

## Requirements
- R1: `boot_sel_i` is sampled only in the first clock cycle after reset. If it is low, the block stays idle: bus released, no transaction, `done_o` and `err_o` low. Later changes of `boot_sel_i` have no effect until the next reset.
- R2: Chip select is active low. The serial clock rests low and has a period of 2*floor(SYS_CLK_HZ/(2*SCK_HZ)) system clocks, which is 32 cycles (1.024 MHz) at the default parameters.
- R3: `mosi_o` changes only together with a falling serial-clock edge, or when chip select is first asserted. `miso_i` is sampled at each rising edge.
- R4: The transaction starts with the read opcode 0x03 and then a 16-bit byte address. Both are sent most-significant bit first, and the address is START_ADDR (0x0010 by default).
- R5: Bytes below START_ADDR (the header area 0x00 to 0x0F) are never clocked in.
- R6: Command codes work as follows. 0xA0, 0xA1, 0xA2 and 0xA3 are followed by 0, 1, 2 and 3 words. 0xFC is the start command and has no words. A command is emitted with `cfg_is_cmd_o`=1 and the byte in bits 7:0, the upper bits zero. A word is emitted with `cfg_is_cmd_o`=0, built from three bytes with the first byte as the most significant.
- R7: While `cfg_valid_o` is high and `cfg_ready_i` is low, the output data and flag stay stable, the serial clock is held low and chip select stays asserted.
- R8: The whole stream is read in one transaction. Chip select is never released between records, and it is released only into the done or error state.
- R9: Once the start command has been accepted, `done_o` goes high, the bus is released and no further item is emitted.
- R10: An unknown command byte is not emitted. The block raises `err_o`, keeps `done_o` low and releases the bus.
- R11: If the byte at address 0xFFFF has been read and the stream is not finished, `err_o` rises after the last emitted item is accepted.
- R12: `bus_oe_o` is high exactly while a transaction is in progress. At reset `bus_oe_o`, `cfg_valid_o`, `done_o` and `err_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| boot_sel_i | input | 1 | Boot source select; high selects the EEPROM load |
| miso_i | input | 1 | Serial data from the EEPROM |
| bus_oe_o | output | 1 | Output enable for the three serial output pins (low means high impedance) |
| cs_n_o | output | 1 | EEPROM chip select, active low |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the EEPROM |
| cfg_valid_o | output | 1 | A command or data word is presented |
| cfg_ready_i | input | 1 | Consumer accepts the presented item |
| cfg_is_cmd_o | output | 1 | High for a command byte, low for a data word |
| cfg_data_o | output | WORD_W | Command byte (zero-extended) or assembled data word |
| done_o | output | 1 | Load finished on the start command |
| err_o | output | 1 | Load aborted (unknown command or address exhausted) |

## Verification
The bench drives a stream that mixes commands with zero to three words and word values at their extremes. The consumer stalls often. A loader that kept clocking the bus during a stall would drop or garble bytes, and one that opened a new transaction after a stall would show up as an extra chip-select fall in the EEPROM model. The header bytes all hold the start-command code, so a loader that read from address 0 would stop early with the wrong item list. Other cases covered:
- An unknown command in mid-stream, which must neither be emitted nor end as done.
- A second instance placed at the top of the address space, which must raise the error after its last word.
- Boot select held low at reset and raised later, which must never start a load.

// File: rtl/spi_boot_loader.sv
module spi_boot_loader #(
  parameter int SYS_CLK_HZ = 32_768_000,
  parameter int SCK_HZ     = 1_024_000,
  parameter int ADDR_W     = 16,
  parameter int WORD_W     = 24,
  parameter logic [ADDR_W-1:0] START_ADDR = 'h10,
  parameter logic [7:0] READ_OP   = 8'h03,
  parameter logic [7:0] START_CMD = 8'hFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_sel_i,
  input  logic              miso_i,
  output logic              bus_oe_o,
  output logic              cs_n_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              cfg_valid_o,
  input  logic              cfg_ready_i,
  output logic              cfg_is_cmd_o,
  output logic [WORD_W-1:0] cfg_data_o,
  output logic              done_o,
  output logic              err_o
);

  localparam int RAW_DIV   = SYS_CLK_HZ / (2 * SCK_HZ);
  localparam int HALF_DIV  = (RAW_DIV < 1) ? 1 : RAW_DIV;
  localparam int DIV_W     = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);
  localparam int HDR_W     = 8 + ADDR_W;
  localparam int HDR_BYTES = HDR_W / 8;
  localparam int HB_W      = $clog2(HDR_BYTES + 1);
  localparam int WBYTES    = WORD_W / 8;
  localparam int WB_W      = (WBYTES < 3) ? 1 : $clog2(WBYTES);

  typedef enum logic [2:0] {S_SAMPLE, S_OFF, S_SHIFT, S_HOLD, S_DONE, S_ERR} st_t;

  st_t               state;
  logic [DIV_W-1:0]  div_cnt;
  logic              sck_q;
  logic [2:0]        bit_cnt;
  logic [HB_W-1:0]   hdr_left;
  logic [HDR_W-1:0]  tx_sr;
  logic [7:0]        rx_sr;
  logic [ADDR_W-1:0] addr;
  logic              want_cmd;
  logic [1:0]        words_left;
  logic [WB_W-1:0]   byte_idx;
  logic [WORD_W-9:0] wbuf;
  logic              term;
  logic              at_end;

  wire tick      = div_cnt == DIV_W'(HALF_DIV - 1);
  wire fall      = tick && sck_q;
  wire rise      = tick && !sck_q;
  wire byte_end  = fall && (bit_cnt == 3'd7);
  wire addr_max  = addr == {ADDR_W{1'b1}};
  wire cmd_term  = rx_sr == START_CMD;
  wire cmd_known = cmd_term || (rx_sr[7:2] == 6'b101000);
  wire [1:0] cmd_words = cmd_term ? 2'd0 : rx_sr[1:0];
  wire word_last = byte_idx == WB_W'(WBYTES - 1);

  assign bus_oe_o = (state == S_SHIFT) || (state == S_HOLD);
  assign cs_n_o   = !bus_oe_o;
  assign sck_o    = sck_q && bus_oe_o;
  assign mosi_o   = tx_sr[HDR_W-1] && bus_oe_o;
  assign done_o   = state == S_DONE;
  assign err_o    = state == S_ERR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_SAMPLE;
      div_cnt      <= '0;
      sck_q        <= 1'b0;
      bit_cnt      <= '0;
      hdr_left     <= '0;
      tx_sr        <= '0;
      rx_sr        <= '0;
      addr         <= '0;
      want_cmd     <= 1'b1;
      words_left   <= '0;
      byte_idx     <= '0;
      wbuf         <= '0;
      term         <= 1'b0;
      at_end       <= 1'b0;
      cfg_valid_o  <= 1'b0;
      cfg_is_cmd_o <= 1'b0;
      cfg_data_o   <= '0;
    end else begin
      case (state)
        S_SAMPLE: begin
          if (boot_sel_i) begin
            state    <= S_SHIFT;
            tx_sr    <= {READ_OP, START_ADDR};
            addr     <= START_ADDR;
            hdr_left <= HB_W'(HDR_BYTES);
          end else begin
            state <= S_OFF;
          end
        end
        S_SHIFT: begin
          div_cnt <= tick ? '0 : div_cnt + 1'b1;
          if (tick) sck_q <= !sck_q;
          if (rise) rx_sr <= {rx_sr[6:0], miso_i};
          if (fall) begin
            tx_sr   <= tx_sr << 1;
            bit_cnt <= bit_cnt + 1'b1;
          end
          if (byte_end) begin
            if (hdr_left != '0) begin
              hdr_left <= hdr_left - 1'b1;
            end else begin
              addr   <= addr + 1'b1;
              at_end <= addr_max;
              if (want_cmd) begin
                if (!cmd_known) begin
                  state <= S_ERR;
                end else begin
                  cfg_valid_o  <= 1'b1;
                  cfg_is_cmd_o <= 1'b1;
                  cfg_data_o   <= WORD_W'(rx_sr);
                  words_left   <= cmd_words;
                  want_cmd     <= cmd_words == 2'd0;
                  term         <= cmd_term;
                  byte_idx     <= '0;
                  state        <= S_HOLD;
                end
              end else if (word_last) begin
                cfg_valid_o  <= 1'b1;
                cfg_is_cmd_o <= 1'b0;
                cfg_data_o   <= {wbuf, rx_sr};
                words_left   <= words_left - 1'b1;
                want_cmd     <= words_left == 2'd1;
                byte_idx     <= '0;
                state        <= S_HOLD;
              end else begin
                wbuf     <= (WORD_W > 16) ? ((wbuf << 8) | (WORD_W-8)'(rx_sr)) : (WORD_W-8)'(rx_sr);
                byte_idx <= byte_idx + 1'b1;
                if (addr_max) state <= S_ERR;
              end
            end
          end
        end
        S_HOLD: begin
          div_cnt <= '0;
          if (cfg_ready_i) begin
            cfg_valid_o <= 1'b0;
            if (term)        state <= S_DONE;
            else if (at_end) state <= S_ERR;
            else             state <= S_SHIFT;
          end
        end
        default: state <= state;
      endcase
    end
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid_o && !cfg_ready_i |=> cfg_valid_o && $stable(cfg_data_o)
      && $stable(cfg_is_cmd_o) && !sck_o && !cs_n_o);

  // R3
  mosi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe_o && $past(bus_oe_o) && !$fell(sck_o) |-> $stable(mosi_o));

  // R8
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_oe_o) && !bus_oe_o |-> done_o || err_o);

  // R9
  done_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(cfg_valid_o && cfg_ready_i && cfg_is_cmd_o));

  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !done_o && !cfg_valid_o && !bus_oe_o);

  // R12
  valid_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid_o |-> bus_oe_o && !cs_n_o);

endmodule

// File: tb/spi_boot_loader_tb_top.sv
module eeprom_model (
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  logic [7:0]  mem [256];
  logic [23:0] hdr;
  logic [15:0] lo;
  logic [15:0] a;
  int          n;
  int          txn;

  initial begin
    miso = 1'b0;
    n = 0;
    txn = 0;
    hdr = '0;
    lo = 16'hFFFF;
  end

  always @(negedge cs_n) begin
    n = 0;
    hdr = '0;
    lo = 16'hFFFF;
    txn++;
  end

  always @(posedge sck) if (!cs_n) begin
    if (n < 24) hdr = {hdr[22:0], mosi};
    n++;
  end

  always @(negedge sck) if (!cs_n && n >= 24) begin
    a = hdr[15:0] + 16'((n - 24) / 8);
    if (a < lo) lo = a;
    miso = mem[a[7:0]][7 - ((n - 24) % 8)];
  end
endmodule

module spi_boot_loader_tb_top;
  localparam int NEXP = 11;
  localparam logic [24:0] EXP [NEXP] = '{
    {1'b1, 24'h0000A2}, {1'b0, 24'h123456}, {1'b0, 24'hABCDEF},
    {1'b1, 24'h0000A0}, {1'b1, 24'h0000A1}, {1'b0, 24'h000001},
    {1'b1, 24'h0000A3}, {1'b0, 24'hFFFFFF}, {1'b0, 24'h800000},
    {1'b0, 24'h5A5AA5}, {1'b1, 24'h0000FC}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boot0 = 1'b0, boot1 = 1'b0;
  logic ready0 = 1'b0;
  logic ready1 = 1'b1;
  logic oe0, cs0, sck0, mosi0, miso0, v0, c0, done0, err0;
  logic oe1, cs1, sck1, mosi1, miso1, v1, c1, done1, err1;
  logic [23:0] d0, d1;
  wire cs0_e  = (oe0 === 1'b1) ? cs0 : 1'b1;
  wire sck0_e = (oe0 === 1'b1) ? sck0 : 1'b0;
  wire cs1_e  = (oe1 === 1'b1) ? cs1 : 1'b1;
  wire sck1_e = (oe1 === 1'b1) ? sck1 : 1'b0;

  int n_chk = 0, n_err = 0;
  logic [24:0] log0 [32];
  logic [24:0] log1 [8];
  int cnt0 = 0, cnt1 = 0;

  always #5 clk = !clk;

  spi_boot_loader #(.SYS_CLK_HZ(100_000_000), .SCK_HZ(12_500_000)) dut_i (
    .clk(clk), .rst_n(rst_n), .boot_sel_i(boot0), .miso_i(miso0),
    .bus_oe_o(oe0), .cs_n_o(cs0), .sck_o(sck0), .mosi_o(mosi0),
    .cfg_valid_o(v0), .cfg_ready_i(ready0), .cfg_is_cmd_o(c0), .cfg_data_o(d0),
    .done_o(done0), .err_o(err0));

  spi_boot_loader #(.SYS_CLK_HZ(100_000_000), .SCK_HZ(12_500_000),
                    .START_ADDR(16'hFFFC)) dut_hi (
    .clk(clk), .rst_n(rst_n), .boot_sel_i(boot1), .miso_i(miso1),
    .bus_oe_o(oe1), .cs_n_o(cs1), .sck_o(sck1), .mosi_o(mosi1),
    .cfg_valid_o(v1), .cfg_ready_i(ready1), .cfg_is_cmd_o(c1), .cfg_data_o(d1),
    .done_o(done1), .err_o(err1));

  eeprom_model mdl0 (.cs_n(cs0_e), .sck(sck0_e), .mosi(mosi0), .miso(miso0));
  eeprom_model mdl1 (.cs_n(cs1_e), .sck(sck1_e), .mosi(mosi1), .miso(miso1));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    int k = 0;
    forever begin
      @(posedge clk);
      #2;
      k++;
      ready0 = (k % 4) == 0;
    end
  end

  logic pv = 1'b0, pr = 1'b0, pc = 1'b0;
  logic [23:0] pd = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pv && !pr)
        chk(v0 === 1'b1 && d0 === pd && c0 === pc && sck0_e === 1'b0 && cs0_e === 1'b0,
            "R7", "stall hold", {v0, c0, sck0_e, cs0_e, d0[23:0]}, {1'b1, pc, 2'b00, pd});
      if (v0 && ready0 && cnt0 < 32) begin
        log0[cnt0] = {c0, d0};
        cnt0++;
      end
      if (v1 && ready1 && cnt1 < 8) begin
        log1[cnt1] = {c1, d1};
        cnt1++;
      end
    end
    pv = v0 === 1'b1;
    pr = ready0;
    pc = c0;
    pd = d0;
  end

  task automatic wait_end(input int lim);
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (done0 || err0) break;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int p;
    int base;
    realtime t0, t1;
    for (int i = 0; i < 256; i++) begin
      mdl0.mem[i] = 8'hFC;
      mdl1.mem[i] = 8'hFC;
    end
    p = 16;
    for (int i = 0; i < NEXP; i++) begin
      if (EXP[i][24]) begin
        mdl0.mem[p] = EXP[i][7:0];
        p++;
      end else begin
        for (int b = 2; b >= 0; b--) begin
          mdl0.mem[p] = EXP[i][8*b +: 8];
          p++;
        end
      end
    end
    mdl1.mem[8'hFC] = 8'hA1;
    mdl1.mem[8'hFD] = 8'h11;
    mdl1.mem[8'hFE] = 8'h22;
    mdl1.mem[8'hFF] = 8'h33;

    repeat (3) @(negedge clk);
    chk(oe0 == 0 && v0 == 0 && done0 == 0 && err0 == 0, "R12", "reset state",
        {oe0, v0, done0, err0}, 4'b0000);
    rst_n = 1'b1;
    repeat (300) @(negedge clk);
    chk(oe0 == 0 && done0 == 0 && err0 == 0 && mdl0.txn == 0, "R1", "boot low idle",
        {oe0, done0, err0, 8'(mdl0.txn)}, 0);
    boot0 = 1'b1;
    repeat (300) @(negedge clk);
    chk(oe0 == 0 && mdl0.txn == 0 && cnt0 == 0, "R1", "late boot select ignored",
        {oe0, 8'(mdl0.txn), 8'(cnt0)}, 0);

    rst_n = 1'b0;
    boot1 = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(posedge sck0_e);
    t0 = $realtime;
    @(posedge sck0_e);
    t1 = $realtime;
    chk(t1 - t0 == 80.0, "R2", "sck period ns", 32'(int'(t1 - t0)), 80);
    chk(cs0_e == 0 && oe0 == 1, "R12", "bus driven while active", {cs0_e, oe0}, 2'b01);
    wait_end(20000);
    chk(done0 == 1 && err0 == 0, "R9", "done after start command", {done0, err0}, 2'b10);
    chk(oe0 == 0 && cs0_e == 1, "R9", "bus released", {oe0, cs0_e}, 2'b01);
    chk(cnt0 == NEXP, "R6", "item count", cnt0, NEXP);
    for (int i = 0; i < NEXP; i++)
      chk(log0[i] === EXP[i], "R6", $sformatf("item %0d", i), 32'(log0[i]), 32'(EXP[i]));
    chk(mdl0.hdr == 24'h030010, "R4", "opcode and address", mdl0.hdr, 24'h030010);
    chk(mdl0.lo >= 16'h0010, "R5", "lowest address read", mdl0.lo, 16'h0010);
    chk(mdl0.txn == 1, "R8", "single transaction", mdl0.txn, 1);
    repeat (200) @(negedge clk);
    chk(cnt0 == NEXP && oe0 == 0, "R9", "quiet after done", {oe0, 8'(cnt0)}, NEXP);

    for (int i = 0; i < 2000 && !err1; i++) @(negedge clk);
    chk(err1 == 1 && done1 == 0 && oe1 == 0, "R11", "address exhausted",
        {err1, done1, oe1}, 3'b100);
    chk(cnt1 == 2 && log1[0] == {1'b1, 24'hA1} && log1[1] == {1'b0, 24'h112233},
        "R11", "items before exhaustion", {8'(cnt1), log1[1][23:0]}, {8'd2, 24'h112233});

    rst_n = 1'b0;
    boot1 = 1'b0;
    mdl0.mem[16] = 8'hA1;
    mdl0.mem[17] = 8'h01;
    mdl0.mem[18] = 8'h02;
    mdl0.mem[19] = 8'h03;
    mdl0.mem[20] = 8'h57;
    base = cnt0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    wait_end(20000);
    chk(err0 == 1 && done0 == 0 && oe0 == 0, "R10", "unknown command stops",
        {err0, done0, oe0}, 3'b100);
    chk(cnt0 - base == 2, "R10", "unknown command not emitted", cnt0 - base, 2);
    chk(log0[base + 1] == {1'b0, 24'h010203}, "R6", "word after A1",
        32'(log0[base + 1]), 32'h010203);
    chk(oe1 == 0 && mdl1.txn == 1, "R1", "second instance idle with boot low",
        {oe1, 8'(mdl1.txn)}, 1);

    finish_run();
  end
endmodule